// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a small embedded controller. Software reaches it through two byte-wide I/O locations with simple read and write strobes. A control register holds four fields: the enable, a timeout span select, a low-power halt mode field, and a constant field. A command register accepts key bytes.

The counter advances only on cycles where the system clock enable `tick` is high. When it reaches the selected span, it raises a one-cycle reset request and starts again from zero. Software keeps the timer quiet by writing the clear key at regular intervals.

Two changes are guarded by keys. Turning the watchdog off needs a key written first. Changing the halt mode needs a different key. Each key lasts for exactly one control register write.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset, the control register reads 83h: enabled, span code 00, halt mode 00. `rst_req` is low.
- R2: A read strobe at address F0h returns the control register as follows.
  - Bit 7: enable.
  - Bits 6:5: span code.
  - Bits 4:3: halt mode.
  - Bits 2:0: always 011, whatever was written there.
  
  A read of any other address, including the command address F1h, returns 00h.
- R3: Every control write loads bits 6:5 as the span code. Code c selects a timeout of 2^(SPAN_LOG2_MIN + 2c) ticks, which is 2^16, 2^18, 2^20 or 2^22 with the default setting.
- R4: A control write with bit 7 = 1 always enables the watchdog. A control write with bit 7 = 0 disables it only when the most recent command write was B1h; otherwise the enable stays set.
- R5: A control write updates the halt mode from bits 4:3 only when the most recent command write was DBh. The codes are 00 idle 1, 01 idle 2, 10 stop, 11 run.
- R6: A pending key (B1h or DBh) is used up by the next control write, whatever that write contains.
- R7: Writing 4Eh to F1h sets the counter to zero. It also counts as a command write, so it cancels any pending key.
- R8: Any other byte written to F1h has no effect: the counter keeps running and a pending key stays pending.
- R9: The counter advances only on cycles where `tick` is high and the watchdog is enabled. While disabled, the counter holds at zero and no reset request is raised.
- R10: `rst_req` goes high for exactly one cycle. This happens on the span-th counted tick after the last clear, enable or previous request, and the count then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for the watchdog counter |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe, acted on at the rising clock edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the same cycle as `io_rd` |
| rst_req | output | 1 | One-cycle timeout reset request |

## Verification
Read data is combinational, so each read result is compared in the same cycle that the strobe is driven. A register write becomes visible in the cycle after its clock edge, so a following read shows the new value. The reset request comes out of a register: with `tick` held high, it is high in the cycle after edge W + span, where W is the edge that took the clear or enable write. The bench counts edges, records that exact cycle in a queue, and flags any request that comes early, late or unexpected. It also flags any expected request that has passed without arriving, and it lengthens the expected time by exactly the number of cycles that `tick` is held low.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        KEY_NONE = 2'd0,
        KEY_DIS  = 2'd1,
        KEY_HALT = 2'd2
    } key_e;

    localparam logic [7:0] CMD_DISARM = 8'hB1;
    localparam logic [7:0] CMD_KICK   = 8'h4E;
    localparam logic [7:0] CMD_HALT   = 8'hDB;
    localparam logic [2:0] FIXED_BITS = 3'b011;

    typedef struct packed {
        logic       en;
        logic [1:0] per;
        logic [1:0] halt;
        key_e       key;
    } ctrl_t;

endpackage

// File: rtl/wdk_decode.sv
module wdk_decode
    import wdk_pkg::*;
#(
    parameter logic [7:0] ADDR_MST = 8'hF0,
    parameter logic [7:0] ADDR_CMD = 8'hF1
) (
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic       mst_wr,
    output logic       key_wr,
    output key_e       key_nx,
    output logic       kick
);
    logic cmd_wr;

    always_comb begin
        mst_wr = io_wr && (io_addr == ADDR_MST);
        cmd_wr = io_wr && (io_addr == ADDR_CMD);
        key_wr = 1'b0;
        key_nx = KEY_NONE;
        kick   = 1'b0;
        if (cmd_wr) begin
            case (io_wdata)
                CMD_DISARM: begin key_wr = 1'b1; key_nx = KEY_DIS;  end
                CMD_HALT:   begin key_wr = 1'b1; key_nx = KEY_HALT; end
                CMD_KICK:   begin key_wr = 1'b1; kick   = 1'b1;     end
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
    import wdk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mst_wr,
    input  logic [7:0] io_wdata,
    input  logic       key_wr,
    input  key_e       key_nx,
    output logic       en,
    output logic [1:0] per,
    output logic [1:0] halt,
    output key_e       key
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (key_wr) begin
            ctrl_d.key = key_nx;
        end
        if (mst_wr) begin
            ctrl_d.per = io_wdata[6:5];
            if (io_wdata[7]) begin
                ctrl_d.en = 1'b1;
            end else if (ctrl_q.key == KEY_DIS) begin
                ctrl_d.en = 1'b0;
            end
            if (ctrl_q.key == KEY_HALT) begin
                ctrl_d.halt = io_wdata[4:3];
            end
            ctrl_d.key = KEY_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{en: 1'b1, per: 2'b00, halt: 2'b00, key: KEY_NONE};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign en   = ctrl_q.en;
    assign per  = ctrl_q.per;
    assign halt = ctrl_q.halt;
    assign key  = ctrl_q.key;
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
    parameter int SPAN_LOG2_MIN = 16,
    parameter int CNT_W         = SPAN_LOG2_MIN + 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             kick,
    input  logic [1:0]       per,
    output logic [CNT_W-1:0] cnt,
    output logic             pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [CNT_W-1:0] last_tab [4];
    logic hit;

    for (genvar g = 0; g < 4; g++) begin : g_span
        assign last_tab[g] = {CNT_W{1'b1}} >> (6 - 2 * g);
    end

    always_comb begin
        cnt_d       = cnt_q;
        cnt_d.pulse = 1'b0;
        hit         = (cnt_q.cnt >= last_tab[per]);
        if (!en || kick) begin
            cnt_d.cnt = '0;
        end else if (tick) begin
            if (hit) begin
                cnt_d.cnt   = '0;
                cnt_d.pulse = 1'b1;
            end else begin
                cnt_d.cnt = cnt_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt   = cnt_q.cnt;
    assign pulse = cnt_q.pulse;
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
    import wdk_pkg::*;
#(
    parameter logic [7:0] ADDR_MST      = 8'hF0,
    parameter logic [7:0] ADDR_CMD      = 8'hF1,
    parameter int         SPAN_LOG2_MIN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       rst_req
);
    localparam int CNT_W = SPAN_LOG2_MIN + 6;

    logic             mst_wr;
    logic             key_wr;
    key_e             key_nx;
    logic             kick;
    logic             en;
    logic [1:0]       per;
    logic [1:0]       halt;
    key_e             key;
    logic [CNT_W-1:0] cnt;

    wdk_decode #(.ADDR_MST(ADDR_MST), .ADDR_CMD(ADDR_CMD)) u_decode (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .mst_wr   (mst_wr),
        .key_wr   (key_wr),
        .key_nx   (key_nx),
        .kick     (kick)
    );

    wdk_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mst_wr   (mst_wr),
        .io_wdata (io_wdata),
        .key_wr   (key_wr),
        .key_nx   (key_nx),
        .en       (en),
        .per      (per),
        .halt     (halt),
        .key      (key)
    );

    wdk_count #(.SPAN_LOG2_MIN(SPAN_LOG2_MIN), .CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .en    (en),
        .kick  (kick),
        .per   (per),
        .cnt   (cnt),
        .pulse (rst_req)
    );

    always_comb begin
        io_rdata = 8'h00;
        if (io_rd && (io_addr == ADDR_MST)) begin
            io_rdata = {en, per, halt, FIXED_BITS};
        end
    end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
#(
    parameter logic [7:0] ADDR_MST = 8'hF0,
    parameter int         CNT_W    = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             en,
    input logic [1:0]       halt,
    input key_e             key,
    input logic [CNT_W-1:0] cnt,
    input logic             kick,
    input logic             rst_req,
    input logic             io_rd,
    input logic [7:0]       io_addr,
    input logic [7:0]       io_rdata
);
    // R2
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == ADDR_MST) |-> io_rdata[2:0] == 3'b011);

    // R4
    disarm_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(key) == KEY_DIS);

    // R5
    halt_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(halt) |-> $past(key) == KEY_HALT);

    // R7
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0 && !rst_req));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !rst_req));

    // R9
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(tick));

    // R10
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

bind wdk_watchdog wdk_checker #(.ADDR_MST(ADDR_MST), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (en),
    .halt     (halt),
    .key      (key),
    .cnt      (cnt),
    .kick     (kick),
    .rst_req  (rst_req),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_rdata (io_rdata)
);

// File: tb/wdk_watchdog_tb.sv
`timescale 1ns/1ps
module wdk_watchdog_tb;
    localparam int BASE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       rst_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pulse_seen = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] exp;
    } rd_item_t;

    typedef struct {
        string req;
        int    at;
    } pulse_item_t;

    rd_item_t    rd_q[$];
    pulse_item_t pulse_q[$];

    wdk_watchdog #(.SPAN_LOG2_MIN(BASE)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .rst_req  (rst_req)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int span(input int code);
        return 1 << (BASE + 2 * code);
    endfunction

    // monitor: compares reads and reset requests against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (io_rd) begin
                rd_item_t it;
                it = rd_q.pop_front();
                total++;
                if (io_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s: read %h expected %h", it.req, io_rdata, it.exp);
                end
            end
            if (pulse_q.size() > 0 && cyc > pulse_q[0].at) begin
                total++;
                bad++;
                $display("FAIL %s: no request by cycle %0d (actual 0, expected 1)",
                         pulse_q[0].req, pulse_q[0].at);
                void'(pulse_q.pop_front());
            end
            if (rst_n && rst_req) begin
                pulse_seen++;
                total++;
                if (pulse_q.size() == 0 || pulse_q[0].at != cyc) begin
                    bad++;
                    $display("FAIL R10: request at cycle %0d expected at %0d", cyc,
                             (pulse_q.size() == 0) ? -1 : pulse_q[0].at);
                end else begin
                    void'(pulse_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        rd_q.push_back('{req, exp});
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic clear_expect(input int code, input int extra, input string req);
        wr(8'hF1, 8'h4E);
        pulse_q.delete();
        pulse_q.push_back('{req, cyc + span(code) + extra});
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check(input bit ok, input int act, input int exp, input string req);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w;
        int n0;
        repeat (4) @(negedge clk);
        check(rst_req == 1'b0, rst_req, 0, "R1");
        rst_n = 1'b1;
        // register phase: tick held low, counter frozen
        rd(8'hF0, 8'h83, "R1");
        rd(8'hF1, 8'h00, "R2");
        rd(8'h10, 8'h00, "R2");
        wr(8'hF0, 8'h23);               // bit7 low, no key
        rd(8'hF0, 8'hA3, "R4");
        wr(8'hF1, 8'hB1); wr(8'hF0, 8'h03);
        rd(8'hF0, 8'h03, "R4");
        wr(8'hF0, 8'h83);
        rd(8'hF0, 8'h83, "R4");
        wr(8'hF0, 8'h9B);               // halt change without key
        rd(8'hF0, 8'h83, "R5");
        wr(8'hF1, 8'hDB); wr(8'hF0, 8'h9B);
        rd(8'hF0, 8'h9B, "R5");
        wr(8'hF0, 8'h83);               // key already used
        rd(8'hF0, 8'h9B, "R6");
        wr(8'hF1, 8'hB1); wr(8'hF0, 8'h9B); wr(8'hF0, 8'h1B);
        rd(8'hF0, 8'h9B, "R6");
        wr(8'hF0, 8'h98);               // bits 2:0 written as 000
        rd(8'hF0, 8'h9B, "R2");
        wr(8'hF1, 8'hB1); wr(8'hF1, 8'h4E); wr(8'hF0, 8'h1B);
        rd(8'hF0, 8'h9B, "R7");
        wr(8'hF1, 8'hB1); wr(8'hF1, 8'h55); wr(8'hF0, 8'h1B);
        rd(8'hF0, 8'h1B, "R8");
        wr(8'hF0, 8'h9B);
        rd(8'hF0, 8'h9B, "R3");

        // timing phase
        @(negedge clk); tick = 1'b1;
        clear_expect(0, 0, "R10");
        w = pulse_q[0].at - span(0);
        pulse_q.push_back('{"R10", w + 2 * span(0)});
        wait_until(w + 2 * span(0) + 2);
        wr(8'hF1, 8'hB1); wr(8'hF0, 8'h1B);
        n0 = pulse_seen;
        repeat (300) @(negedge clk);
        check(pulse_seen == n0, pulse_seen - n0, 0, "R9");
        rd(8'hF0, 8'h1B, "R9");

        wr(8'hF0, 8'hBB);               // enable, span code 01
        w = cyc;
        pulse_q.push_back('{"R3", w + span(1)});
        wait_until(w + 100);
        wr(8'hF1, 8'h55);               // must not clear
        wait_until(w + span(1) + 4);

        wr(8'hF0, 8'hDB);               // span code 10
        clear_expect(2, 20, "R9");
        repeat (10) @(negedge clk);
        tick = 1'b0;
        repeat (20) @(negedge clk);
        tick = 1'b1;
        wait_until(pulse_q[0].at + 4);

        clear_expect(2, 0, "R7");
        w = cyc;
        wait_until(w + 500);
        clear_expect(2, 0, "R7");
        wait_until(pulse_q[0].at + 4);

        check(pulse_q.size() == 0, pulse_q.size(), 0, "R10");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule